// File: doc/BRIEF.md
# Atomic Fetch-and-Add Counter Bank

The block keeps a 2048-byte bank of signed counters. Each counter can be read and updated as an 8-, 16-, 32- or 64-bit quantity. Counters sit big-endian inside 64-bit words, so narrow counters that share a word occupy separate byte lanes. A requester reaches the bank through one request channel and gets every answer back on one response channel. Both channels are simple valid/ready pairs.

There are three request kinds. A fetch-type request adds an increment to a counter and returns the value from before the add; the signed increment is carried in the request address. A store-type request either adds the store data to a counter or overwrites it. An asynchronous command word performs a fetch-and-add and returns the old value tagged with a scratchpad word address, which the downstream scratchpad writer uses.

Fetch-type and asynchronous requests may ask to wait for an external tag-switch-complete signal before the update. The wait is bounded by a programmable cycle limit. Requests are serviced strictly one at a time, so every read-modify-write is atomic.

Top module: `fau_unit`

## Requirements
- R1: After reset every counter reads as zero, `req_ready_o` is 1 and `rsp_valid_o` is 0.
- R2: Fetch request (`req_kind_i`=0). The operand size is taken from `req_size_i`: 0 is 8 bits, 1 is 16 bits, 2 is 32 bits, 3 is 64 bits. The register byte address is in `req_addr_i[10:0]`. The increment is the 22-bit signed field `req_addr_i[35:14]`. The counter becomes old+increment, wrapping modulo the operand width. The response data is the old value sign-extended to 64 bits.
- R3: Store request (`req_kind_i`=1). With `req_addr_i[13]`=0 the low operand-width bits of `req_wdata_i` are added to the counter. With `req_addr_i[13]`=1 they overwrite it. The response returns the old value, sign-extended.
- R4: Asynchronous request (`req_kind_i`=2). The command word in `req_addr_i` uses these fields: [63:56] scratchpad word address, [55:48] length, [35:14] increment, [13] tag-wait, [12:11] size, [10:0] register. The fetch-and-add behaves as in R2. The response has `rsp_kind_o`=2 and `rsp_scr_o` equal to bits 63:56.
- R5: Register byte r lives in word r/8, at bits 63-8*(r%8) down to 56-8*(r%8), so byte 0 is the most significant byte. Only the bytes of the addressed counter change.
- R6: Certain requests are rejected: a register address not aligned to the operand size, an asynchronous length other than 1, or `req_kind_i`=3. A rejected request changes nothing and responds with `rsp_err_o`=1 and data 0.
- R7: When bit 13 is set on a fetch or asynchronous request, the update waits while `tag_done_i` is 0 and happens in the first cycle it is 1. On success the response carries bit 63 = 0 and, in bits 62:0, the low 63 bits of the sign-extended old value.
- R8: A tag-wait request that sees no `tag_done_i` for the limit number of cycles times out. The limit is 1024 after reset and is reloaded from `cfg_tmo_i` when `cfg_tmo_we_i` is 1. A timed-out request leaves the counter unchanged, sets `rsp_err_o`=1 and returns data 0x8000_0000_0000_0000. The response appears exactly limit cycles after acceptance, where a plain request takes 1 cycle.
- R9: From acceptance until its response is taken, `req_ready_o` stays 0. While `rsp_valid_o`=1 and `rsp_ready_i`=0, all response outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_tmo_we_i | input | 1 | Load a new tag-wait limit |
| cfg_tmo_i | input | 16 | Tag-wait limit in cycles |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_kind_i | input | 2 | 0 fetch, 1 store, 2 asynchronous, 3 rejected |
| req_size_i | input | 2 | Operand size for fetch and store |
| req_addr_i | input | 64 | Request address or asynchronous command word |
| req_wdata_i | input | 64 | Store data |
| tag_done_i | input | 1 | Tag switch complete |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response taken when high with valid |
| rsp_kind_o | output | 2 | Kind of the request answered |
| rsp_err_o | output | 1 | Rejected or timed out |
| rsp_scr_o | output | 8 | Scratchpad word address of an asynchronous request |
| rsp_data_o | output | 64 | Old counter value or error pattern |

## Verification
The bench keeps a byte-wide big-endian model of the bank. It drives mixed random requests over a few overlapping words. A wrong lane shift or byte enable then shows up as a corrupted neighbour counter rather than going unnoticed. Directed cases go after the following:
- an 8-bit wrap from 0x7F to 0x80, which a design without sign extension would return as 0x80;
- the most negative 22-bit increment on a 64-bit counter, which exposes a truncated increment;
- misaligned and bad-length requests, which a lax design would apply;
- a tag-wait that completes late, which a design that ignores the wait would answer early;
- timeouts at the reset limit and at a programmed limit, checked for exact latency and for an untouched counter;
- a stalled response that must hold its value and block new requests.

// File: rtl/fau_pkg.sv
package fau_pkg;
  localparam int DATA_W     = 64;
  localparam int REG_W      = 11;
  localparam int INC_W      = 22;
  localparam int SCR_W      = 8;
  localparam int LEN_W      = 8;
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int OFF_W      = $clog2(WORD_BYTES);
  localparam int WORDS      = (1 << REG_W) / WORD_BYTES;
  localparam int IDX_W      = $clog2(WORDS);
  // field positions shared by fetch and asynchronous words
  localparam int FLAG_BIT   = 13;
  localparam int SIZE_LSB   = 11;
  localparam int INC_LSB    = 14;
  localparam int LEN_LSB    = 48;
  localparam int SCR_LSB    = 56;

  typedef enum logic [1:0] {
    OP_FETCH = 2'd0,
    OP_STORE = 2'd1,
    OP_ASYNC = 2'd2,
    OP_RSVD  = 2'd3
  } op_kind_e;

  typedef struct packed {
    op_kind_e          kind;
    logic [SCR_W-1:0]  scr;
    logic [1:0]        size;
    logic [REG_W-1:0]  reg_a;
    logic [DATA_W-1:0] operand;
    logic              tw;
    logic              ovr;
    logic              bad;
  } fau_req_t;

  function automatic logic [DATA_W-1:0] sext_sz(logic [DATA_W-1:0] v, logic [1:0] sz);
    case (sz)
      2'd0:    return {{(DATA_W-8){v[7]}}, v[7:0]};
      2'd1:    return {{(DATA_W-16){v[15]}}, v[15:0]};
      2'd2:    return {{(DATA_W-32){v[31]}}, v[31:0]};
      default: return v;
    endcase
  endfunction
endpackage

// File: rtl/fau_tmo.sv
module fau_tmo #(
  parameter int TMO_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             expired_o
);
  logic [TMO_W-1:0] cnt_q;
  logic [TMO_W:0]   nxt;

  assign nxt       = {1'b0, cnt_q} + 1'b1;
  assign expired_o = run_i && (nxt >= {1'b0, limit_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (!run_i)     cnt_q <= '0;
    else if (!expired_o) cnt_q <= nxt[TMO_W-1:0];
  end
endmodule

// File: rtl/fau_decode.sv
module fau_decode
  import fau_pkg::*;
(
  input  logic [1:0]        kind_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output fau_req_t          req_o
);
  op_kind_e          kind;
  logic [1:0]        size;
  logic [REG_W-1:0]  reg_a;
  logic [INC_W-1:0]  inc;
  logic              misal;
  logic              bad_len;
  logic              unused_bits;

  assign kind    = op_kind_e'(kind_i);
  assign size    = (kind == OP_ASYNC) ? addr_i[SIZE_LSB +: 2] : size_i;
  assign reg_a   = addr_i[REG_W-1:0];
  assign inc     = addr_i[INC_LSB +: INC_W];
  assign bad_len = (kind == OP_ASYNC) && (addr_i[LEN_LSB +: LEN_W] != LEN_W'(1));
  assign unused_bits = ^addr_i[LEN_LSB-1:INC_LSB+INC_W];

  always_comb begin
    case (size)
      2'd1:    misal = reg_a[0];
      2'd2:    misal = |reg_a[1:0];
      2'd3:    misal = |reg_a[2:0];
      default: misal = 1'b0;
    endcase
  end

  always_comb begin
    req_o.kind    = kind;
    req_o.scr     = addr_i[SCR_LSB +: SCR_W];
    req_o.size    = size;
    req_o.reg_a   = reg_a;
    req_o.operand = (kind == OP_STORE) ? wdata_i
                                       : {{(DATA_W-INC_W){inc[INC_W-1]}}, inc};
    req_o.tw      = (kind != OP_STORE) && addr_i[FLAG_BIT];
    req_o.ovr     = (kind == OP_STORE) && addr_i[FLAG_BIT];
    req_o.bad     = misal || bad_len || (kind == OP_RSVD);
  end
endmodule

// File: rtl/fau_lane.sv
module fau_lane
  import fau_pkg::*;
(
  input  logic [DATA_W-1:0] word_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic              ovr_i,
  output logic [DATA_W-1:0] old_o,
  output logic [DATA_W-1:0] word_o
);
  logic [OFF_W-1:0]      nb_m1;
  logic [OFF_W-1:0]      lsb_byte;
  logic [OFF_W+2:0]      sh;
  logic [WORD_BYTES-1:0] span;
  logic [WORD_BYTES-1:0] be;
  logic [DATA_W-1:0]     field;
  logic [DATA_W-1:0]     sum;
  logic [DATA_W-1:0]     placed;

  always_comb begin
    case (size_i)
      2'd0:    begin nb_m1 = 3'd0; span = 8'h01; end
      2'd1:    begin nb_m1 = 3'd1; span = 8'h03; end
      2'd2:    begin nb_m1 = 3'd3; span = 8'h0F; end
      default: begin nb_m1 = 3'd7; span = 8'hFF; end
    endcase
  end

  // big-endian: byte offset 0 is the top byte of the word
  assign lsb_byte = 3'd7 - off_i - nb_m1;
  assign sh       = {lsb_byte, 3'b000};
  assign be       = span << lsb_byte;
  assign field    = word_i >> sh;
  assign old_o    = sext_sz(field, size_i);
  assign sum      = ovr_i ? operand_i : field + operand_i;
  assign placed   = sum << sh;

  for (genvar b = 0; b < WORD_BYTES; b++) begin : g_byte
    assign word_o[8*b +: 8] = be[b] ? placed[8*b +: 8] : word_i[8*b +: 8];
  end
endmodule

// File: rtl/fau_unit.sv
module fau_unit
  import fau_pkg::*;
#(
  parameter int TMO_W   = 16,
  parameter int TMO_RST = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_tmo_we_i,
  input  logic [TMO_W-1:0]  cfg_tmo_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_kind_i,
  input  logic [1:0]        req_size_i,
  input  logic [DATA_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              tag_done_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [1:0]        rsp_kind_o,
  output logic              rsp_err_o,
  output logic [SCR_W-1:0]  rsp_scr_o,
  output logic [DATA_W-1:0] rsp_data_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_EXEC, ST_RESP} state_e;

  state_e            state_q;
  fau_req_t          dec, cur_q;
  logic [DATA_W-1:0] mem_q [WORDS];
  logic [TMO_W-1:0]  tmo_q;
  logic [DATA_W-1:0] old_val, new_word;
  logic              accept, in_exec, waiting, expired, mem_we, tmo_fire, done;
  logic [DATA_W-1:0] rsp_data_q;
  logic              rsp_err_q;
  logic [1:0]        rsp_kind_q;
  logic [SCR_W-1:0]  rsp_scr_q;

  fau_decode u_dec (
    .kind_i  (req_kind_i),
    .size_i  (req_size_i),
    .addr_i  (req_addr_i),
    .wdata_i (req_wdata_i),
    .req_o   (dec)
  );

  fau_lane u_lane (
    .word_i    (mem_q[cur_q.reg_a[REG_W-1:OFF_W]]),
    .off_i     (cur_q.reg_a[OFF_W-1:0]),
    .size_i    (cur_q.size),
    .operand_i (cur_q.operand),
    .ovr_i     (cur_q.ovr),
    .old_o     (old_val),
    .word_o    (new_word)
  );

  fau_tmo #(.TMO_W(TMO_W)) u_tmo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (waiting),
    .limit_i   (tmo_q),
    .expired_o (expired)
  );

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign in_exec     = (state_q == ST_EXEC);
  assign waiting     = in_exec && !cur_q.bad && cur_q.tw && !tag_done_i;
  assign mem_we      = in_exec && !cur_q.bad && (!cur_q.tw || tag_done_i);
  assign tmo_fire    = waiting && expired;
  assign done        = in_exec && (cur_q.bad || mem_we || tmo_fire);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tmo_q <= TMO_W'(TMO_RST);
    else if (cfg_tmo_we_i) tmo_q <= cfg_tmo_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cur_q <= '0;
    else if (accept) cur_q <= dec;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
    end else if (mem_we) begin
      mem_q[cur_q.reg_a[REG_W-1:OFF_W]] <= new_word;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      rsp_data_q <= '0;
      rsp_err_q  <= 1'b0;
      rsp_kind_q <= '0;
      rsp_scr_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) state_q <= ST_EXEC;
        ST_EXEC: if (done) begin
          state_q    <= ST_RESP;
          rsp_kind_q <= cur_q.kind;
          rsp_scr_q  <= cur_q.scr;
          rsp_err_q  <= cur_q.bad || tmo_fire;
          if (cur_q.bad)     rsp_data_q <= '0;
          else if (tmo_fire) rsp_data_q <= {1'b1, {(DATA_W-1){1'b0}}};
          else if (cur_q.tw) rsp_data_q <= {1'b0, old_val[DATA_W-2:0]};
          else               rsp_data_q <= old_val;
        end
        ST_RESP: if (rsp_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid_o = (state_q == ST_RESP);
  assign rsp_data_o  = rsp_data_q;
  assign rsp_err_o   = rsp_err_q;
  assign rsp_kind_o  = rsp_kind_q;
  assign rsp_scr_o   = rsp_scr_q;
endmodule

// File: rtl/fau_unit_chk.sv
module fau_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic        rsp_valid_o,
  input logic        rsp_ready_i,
  input logic [1:0]  rsp_kind_o,
  input logic        rsp_err_o,
  input logic [7:0]  rsp_scr_o,
  input logic [63:0] rsp_data_o,
  input logic        tag_done_i,
  input logic        in_exec,
  input logic        mem_we,
  input logic        cur_tw,
  input logic        cur_bad,
  input logic        tmo_fire
);
  // R9
  rsp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_data_o) &&
      $stable(rsp_err_o) && $stable(rsp_kind_o) && $stable(rsp_scr_o));

  // R9
  single_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_ready_o && rsp_valid_o));

  // R9
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> in_exec && !req_ready_o);

  // R1
  rsp_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rsp_valid_o) |-> $past(in_exec));

  // R7
  tag_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we && cur_tw |-> tag_done_i);

  // R8
  tmo_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_fire |-> !mem_we);

  // R8
  tmo_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_fire |=> rsp_valid_o && rsp_err_o && rsp_data_o[63]);

  // R6
  reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_exec && cur_bad |-> !mem_we);

  // R6
  reject_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_exec && cur_bad |=> rsp_valid_o && rsp_err_o && (rsp_data_o == 64'd0));
endmodule

bind fau_unit fau_unit_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_ready_i (rsp_ready_i),
  .rsp_kind_o  (rsp_kind_o),
  .rsp_err_o   (rsp_err_o),
  .rsp_scr_o   (rsp_scr_o),
  .rsp_data_o  (rsp_data_o),
  .tag_done_i  (tag_done_i),
  .in_exec     (in_exec),
  .mem_we      (mem_we),
  .cur_tw      (cur_q.tw),
  .cur_bad     (cur_q.bad),
  .tmo_fire    (tmo_fire)
);

// File: tb/fau_unit_test.sv
module fau_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_tmo = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = '0;
  logic [1:0]  req_size = '0;
  logic [63:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic        tag_done = 1'b1;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [1:0]  rsp_kind;
  logic        rsp_err;
  logic [7:0]  rsp_scr;
  logic [63:0] rsp_data;

  int unsigned checks = 0;
  int unsigned fails  = 0;
  int unsigned cyc    = 0;
  bit          finished = 0;

  logic [63:0] r_data;
  logic        r_err;
  logic [1:0]  r_kind;
  logic [7:0]  r_scr;
  int unsigned lat;
  logic [7:0]  mdl [2048];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fau_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_tmo_we_i(cfg_we), .cfg_tmo_i(cfg_tmo),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_kind_i(req_kind),
    .req_size_i(req_size), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .tag_done_i(tag_done), .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_kind_o(rsp_kind), .rsp_err_o(rsp_err), .rsp_scr_o(rsp_scr),
    .rsp_data_o(rsp_data)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_fetch(logic [21:0] inc, logic tw, logic [10:0] r);
    return {28'h0, inc, tw, 2'b00, r};
  endfunction
  function automatic logic [63:0] mk_store(logic ovr, logic [10:0] r);
    return {50'h0, ovr, 2'b00, r};
  endfunction
  function automatic logic [63:0] mk_async(logic [7:0] scr, logic [7:0] len, logic [21:0] inc,
                                           logic tw, logic [1:0] sz, logic [10:0] r);
    return {scr, len, 12'h0, inc, tw, sz, r};
  endfunction

  function automatic logic [63:0] sx(logic [63:0] v, int n);
    case (n)
      1: return {{56{v[7]}}, v[7:0]};
      2: return {{48{v[15]}}, v[15:0]};
      4: return {{32{v[31]}}, v[31:0]};
      default: return v;
    endcase
  endfunction

  // byte-addressed big-endian reference model
  task automatic predict(input logic [1:0] k, input logic [63:0] a, input logic [1:0] szi,
                         input logic [63:0] wd, output logic [63:0] ed, output logic ee);
    int r; int n; logic [1:0] sz; logic [63:0] old; logic [63:0] op; logic [63:0] nv;
    r  = int'(a[10:0]);
    sz = (k == 2'd2) ? a[12:11] : szi;
    n  = 1 << sz;
    if ((r % n) != 0 || k == 2'd3 || (k == 2'd2 && a[55:48] != 8'd1)) begin
      ed = '0; ee = 1'b1;
      return;
    end
    old = '0;
    for (int i = 0; i < n; i++) old = (old << 8) | 64'(mdl[r+i]);
    op = (k == 2'd1) ? wd : {{42{a[35]}}, a[35:14]};
    nv = (k == 2'd1 && a[13]) ? op : old + op;
    for (int i = 0; i < n; i++) mdl[r+i] = 8'(nv >> (8*(n-1-i)));
    ed = sx(old, n);
    if (k != 2'd1 && a[13]) ed[63] = 1'b0;
    ee = 1'b0;
  endtask

  task automatic issue(input logic [1:0] k, input logic [63:0] a, input logic [1:0] sz,
                       input logic [63:0] wd, input int hold);
    int unsigned c0;
    @(negedge clk);
    if (hold > 0) rsp_ready = 1'b0;
    req_valid = 1'b1; req_kind = k; req_addr = a; req_size = sz; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
    c0 = cyc;
    do @(negedge clk); while (!rsp_valid);
    lat = cyc - c0;
    r_data = rsp_data; r_err = rsp_err; r_kind = rsp_kind; r_scr = rsp_scr;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      // R9: held response and blocked request side
      chk("R9 hold valid", {63'd0, rsp_valid}, 64'd1);
      chk("R9 hold data", rsp_data, r_data);
      chk("R9 busy", {63'd0, req_ready}, 64'd0);
    end
    rsp_ready = 1'b1;
  endtask

  task automatic do_op(string tag, logic [1:0] k, logic [63:0] a, logic [1:0] sz, logic [63:0] wd);
    logic [63:0] ed; logic ee;
    predict(k, a, sz, wd, ed, ee);
    issue(k, a, sz, wd, 0);
    chk(tag, r_data, ed);
    chk(tag, {63'd0, r_err}, {63'd0, ee});
    chk(tag, {62'd0, r_kind}, {62'd0, k});
    if (k == 2'd2) chk(tag, {56'd0, r_scr}, {56'd0, a[63:56]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] ed; logic ee;
    for (int i = 0; i < 2048; i++) mdl[i] = 8'h00;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 ready", {63'd0, req_ready}, 64'd1);
    chk("R1 valid", {63'd0, rsp_valid}, 64'd0);
    issue(2'd0, mk_fetch(22'd0, 1'b0, 11'd0), 2'd3, '0, 0);
    chk("R1 zero lo", r_data, 64'd0);
    issue(2'd0, mk_fetch(22'd0, 1'b0, 11'd2040), 2'd3, '0, 0);
    chk("R1 zero hi", r_data, 64'd0);
    chk("R8 plain latency", 64'(lat), 64'd1);

    // R5 lane placement
    do_op("R5 st8", 2'd1, mk_store(1'b1, 11'd3), 2'd0, 64'hA5);
    issue(2'd0, mk_fetch(22'd0, 1'b0, 11'd0), 2'd3, '0, 0);
    chk("R5 byte3", r_data, 64'h0000_00A5_0000_0000);
    do_op("R5 st16", 2'd1, mk_store(1'b1, 11'd6), 2'd1, 64'hFFFF_1234);
    issue(2'd0, mk_fetch(22'd0, 1'b0, 11'd0), 2'd3, '0, 0);
    chk("R5 half3", r_data, 64'h0000_00A5_0000_1234);
    do_op("R2 sext8", 2'd0, mk_fetch(22'h3FFFFF, 1'b0, 11'd3), 2'd0, '0);
    chk("R2 sext8 direct", r_data, 64'hFFFF_FFFF_FFFF_FFA5);

    // R2 wrap and wide increment
    do_op("R3 ovr", 2'd1, mk_store(1'b1, 11'd8), 2'd0, 64'h7F);
    do_op("R2 inc", 2'd0, mk_fetch(22'd1, 1'b0, 11'd8), 2'd0, '0);
    chk("R2 old 7f", r_data, 64'h7F);
    issue(2'd0, mk_fetch(22'd0, 1'b0, 11'd8), 2'd0, '0, 0);
    chk("R2 wrap", r_data, 64'hFFFF_FFFF_FFFF_FF80);
    do_op("R2 neg", 2'd0, mk_fetch(22'h200000, 1'b0, 11'd16), 2'd3, '0);
    issue(2'd0, mk_fetch(22'd0, 1'b0, 11'd16), 2'd3, '0, 0);
    chk("R2 neg64", r_data, 64'hFFFF_FFFF_FFE0_0000);

    // R3 store add
    do_op("R3 add", 2'd1, mk_store(1'b0, 11'd24), 2'd2, 64'h10);
    do_op("R3 add neg", 2'd1, mk_store(1'b0, 11'd24), 2'd2, 64'hFFFF_FFFF);
    issue(2'd0, mk_fetch(22'd0, 1'b0, 11'd24), 2'd2, '0, 0);
    chk("R3 sum", r_data, 64'hF);

    // R6 rejects
    do_op("R6 misalign", 2'd0, mk_fetch(22'd5, 1'b0, 11'd26), 2'd2, '0);
    chk("R6 misalign err", {63'd0, r_err}, 64'd1);
    do_op("R6 len", 2'd2, mk_async(8'h11, 8'd2, 22'd5, 1'b0, 2'd2, 11'd24), 2'd0, '0);
    chk("R6 len err", {63'd0, r_err}, 64'd1);
    do_op("R6 kind3", 2'd3, mk_fetch(22'd5, 1'b0, 11'd24), 2'd2, '0);
    issue(2'd0, mk_fetch(22'd0, 1'b0, 11'd24), 2'd2, '0, 0);
    chk("R6 untouched", r_data, 64'hF);

    // R4 asynchronous
    do_op("R4 async", 2'd2, mk_async(8'h5C, 8'd1, 22'd3, 1'b0, 2'd2, 11'd24), 2'd0, '0);
    chk("R4 scr", {56'd0, r_scr}, 64'h5C);
    chk("R4 old", r_data, 64'hF);
    issue(2'd0, mk_fetch(22'd0, 1'b0, 11'd24), 2'd2, '0, 0);
    chk("R4 new", r_data, 64'h12);

    // R7 delayed tag switch
    tag_done = 1'b0;
    predict(2'd0, mk_fetch(22'd7, 1'b1, 11'd40), 2'd3, '0, ed, ee);
    fork
      issue(2'd0, mk_fetch(22'd7, 1'b1, 11'd40), 2'd3, '0, 0);
      begin
        repeat (6) @(negedge clk);
        chk("R7 stalled", {63'd0, rsp_valid}, 64'd0);
        tag_done = 1'b1;
      end
    join
    chk("R7 data", r_data, ed);
    chk("R7 err", {63'd0, r_err}, 64'd0);
    do_op("R7 applied", 2'd0, mk_fetch(22'd0, 1'b0, 11'd40), 2'd3, '0);
    chk("R7 value", r_data, 64'd7);

    // R8 timeout at reset limit, then programmed limit
    tag_done = 1'b0;
    issue(2'd0, mk_fetch(22'd9, 1'b1, 11'd40), 2'd3, '0, 0);
    chk("R8 lat1024", 64'(lat), 64'd1024);
    chk("R8 data", r_data, 64'h8000_0000_0000_0000);
    chk("R8 err", {63'd0, r_err}, 64'd1);
    @(negedge clk); cfg_we = 1'b1; cfg_tmo = 16'd20;
    @(negedge clk); cfg_we = 1'b0;
    issue(2'd2, mk_async(8'h33, 8'd1, 22'd9, 1'b1, 2'd3, 11'd40), 2'd0, '0, 0);
    chk("R8 lat20", 64'(lat), 64'd20);
    chk("R8 async err", {63'd0, r_err}, 64'd1);
    chk("R8 async scr", {56'd0, r_scr}, 64'h33);
    tag_done = 1'b1;
    do_op("R8 unchanged", 2'd0, mk_fetch(22'd0, 1'b0, 11'd40), 2'd3, '0);
    chk("R8 value", r_data, 64'd7);

    // R9 stalled response
    predict(2'd1, mk_store(1'b0, 11'd48), 2'd1, 64'h55, ed, ee);
    issue(2'd1, mk_store(1'b0, 11'd48), 2'd1, 64'h55, 4);
    chk("R9 data", r_data, ed);

    // random mix over a few shared words
    for (int n = 0; n < 400; n++) begin
      logic [1:0] k; logic [1:0] sz; logic [10:0] r; logic [63:0] a; logic [63:0] wd;
      logic [7:0] len;
      k  = 2'($urandom_range(0, 2));
      sz = 2'($urandom_range(0, 3));
      r  = 11'($urandom_range(0, 31));
      if ($urandom_range(0, 7) != 0) r = r & ~((11'd1 << sz) - 11'd1);
      len = ($urandom_range(0, 15) == 0) ? 8'd3 : 8'd1;
      wd = {$urandom, $urandom};
      case (k)
        2'd0:    a = mk_fetch(22'($urandom), 1'($urandom), r);
        2'd1:    a = mk_store(1'($urandom), r);
        default: a = mk_async(8'($urandom), len, 22'($urandom), 1'($urandom), sz, r);
      endcase
      case (k)
        2'd0:    do_op("R2 rand", k, a, sz, wd);
        2'd1:    do_op("R3 rand", k, a, sz, wd);
        default: do_op("R4 rand", k, a, sz, wd);
      endcase
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule